// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Port with Receiver Wakeup

This block is a full-duplex asynchronous serial port for multi-drop links. It sends and receives characters of either eight or nine data bits. Both directions have two stages of buffering. The transmit side has a holding register that feeds a shift register. The receive side has a deframer that feeds a read buffer. Software can therefore queue the next character while the current one is still on the line, and can read a finished character while the next one arrives. One data port serves both directions: a write strobe loads the transmit holding register, and a read strobe takes the receive buffer and clears its flags.

For networks with one master and many listeners, the receiver can be put to sleep. While it sleeps, characters do not reach the read buffer. It wakes on one of two conditions, chosen by a configuration pin. The first is a full character time of idle line. The second is a character whose most significant data bit is 1, called an address mark. In nine-bit mode the ninth bit has its own input for transmit and its own output for receive.

All bit timing comes from an external tick that pulses at sixteen times the bit rate. The receiver samples each bit three times around its centre and takes the majority value.

Top module: `uart9_wake`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `tx_empty` and `tx_done` are 1, and `rx_full`, `rx_overrun`, `rx_frame_err`, `rx_idle` and `rx_asleep` are 0.
- R2: With `cfg_nine`=0 the transmitter sends a frame of 10 bits, each 16 ticks long. The frame is a start bit of 0, then `wr_data` bit 0 through bit 7, then a stop bit of 1. Between frames `txd` is held at 1.
- R3: With `cfg_nine`=1 a frame has 9 data bits. The ninth bit is sent after data bit 7 and comes from `tx_bit8`, sampled on the write strobe. On receive, the ninth bit appears on `rx_bit8`.
- R4: A write is accepted only while `tx_empty` is 1. The held character moves into the shifter as soon as the shifter is free, so a second character follows the first with no gap. A write made while `tx_empty` is 0 is dropped. `tx_done` is 1 only when both stages are empty.
- R5: When a received frame completes, its data bits appear on `rd_data` (bit 0 first on the line) and `rx_full` is set. A `data_rd` pulse clears `rx_full`, `rx_overrun` and `rx_frame_err`.
- R6: If a frame completes while `rx_full` is still 1, `rx_overrun` is set and `rd_data` keeps the earlier character.
- R7: A stop bit voted as 0 still delivers the character, but sets `rx_frame_err`.
- R8: With `cfg_wake_addr`=1, a `sleep_req` pulse sets `rx_asleep`. While asleep, characters whose most significant data bit is 0 (bit 7 in eight-bit mode, the ninth bit in nine-bit mode) are discarded. The first character with that bit set clears `rx_asleep` and is delivered.
- R9: With `cfg_wake_addr`=0, `rx_asleep` clears once the line has been 1 for a full frame length (10 or 11 bit times) counted from after the `sleep_req` pulse. Characters that arrive while asleep are discarded.
- R10: `rx_idle` goes to 1 when the line has stayed 1 for a full frame length after a delivered character. It goes back to 0 when the next start bit is detected.
- R11: Each bit is decided by a majority of three samples taken at ticks 7, 8 and 9 of the bit. A low pulse of one tick on an idle line does not start a frame, and a one-tick glitch inside a data bit does not change that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud16_tick | input | 1 | Pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| data_wr | input | 1 | Write strobe into the transmit holding register |
| data_rd | input | 1 | Read strobe: takes the receive buffer and clears its flags |
| wr_data | input | 8 | Character to transmit |
| rd_data | output | 8 | Last delivered received character |
| cfg_nine | input | 1 | 1 = nine data bits per frame, 0 = eight |
| cfg_wake_addr | input | 1 | Wake condition: 1 = address mark, 0 = idle line |
| tx_bit8 | input | 1 | Ninth transmit bit, captured with the write |
| rx_bit8 | output | 1 | Ninth bit of the last delivered character |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| rx_asleep | output | 1 | Receiver is sleeping |
| tx_empty | output | 1 | Holding register can accept a write |
| tx_done | output | 1 | Holding register and shifter are both empty |
| rx_full | output | 1 | An unread character is in the read buffer |
| rx_overrun | output | 1 | A character was lost because the buffer was full |
| rx_frame_err | output | 1 | The buffered character had a stop bit of 0 |
| rx_idle | output | 1 | The line has been idle for a frame length since the last character |

## Verification
The hardest case to reach is the boundary of the idle-line wake, because the idle counter must restart at the moment the receiver falls asleep. The bench issues `sleep_req` while the line is already idle and starts a character right away. It then checks that the receiver is still asleep at eight bit times and awake by twelve bit times. For address-mark wake, a discarded non-address character is sent before the waking one, in both eight- and nine-bit modes. Majority voting is exercised with one-tick pulses, placed on the idle line and in the middle of a data bit.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic {RX_IDLE = 1'b0, RX_RUN = 1'b1} rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          nine_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          b8_i,
  output logic          txd_o,
  output logic          empty_o,
  output logic          done_o
);
  localparam int SW = DW + 2;              // stop, bit8 slot, data
  localparam int TW = $clog2(OVS);
  localparam int IW = $clog2(DW + 4);
  localparam logic [IW-1:0] LEN9  = IW'(DW + 3);
  localparam logic [IW-1:0] LEN8  = IW'(DW + 2);
  localparam logic [IW-1:0] ONE   = IW'(1);
  localparam logic [TW-1:0] TLAST = TW'(OVS - 1);

  logic [DW-1:0] hold_data;
  logic          hold_b8;
  logic          hold_full;
  logic          busy;
  logic [SW-1:0] sh;
  logic [IW-1:0] bits_left;
  logic [TW-1:0] tcnt;
  logic          txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_b8   <= 1'b0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sh        <= '1;
      bits_left <= '0;
      tcnt      <= '0;
      txd_q     <= 1'b1;
    end else begin
      if (wr_i && !hold_full) begin
        hold_data <= wr_data_i;
        hold_b8   <= b8_i;
        hold_full <= 1'b1;
      end
      if (!busy && hold_full) begin
        busy      <= 1'b1;
        hold_full <= 1'b0;
        sh        <= {1'b1, (nine_i ? hold_b8 : 1'b1), hold_data};
        bits_left <= nine_i ? LEN9 : LEN8;
        tcnt      <= '0;
        txd_q     <= 1'b0;
      end else if (busy && tick_i) begin
        if (tcnt == TLAST) begin
          tcnt <= '0;
          if (bits_left == ONE) begin
            busy  <= 1'b0;
            txd_q <= 1'b1;
          end else begin
            txd_q     <= sh[0];
            sh        <= {1'b1, sh[SW-1:1]};
            bits_left <= bits_left - ONE;
          end
        end else begin
          tcnt <= tcnt + TW'(1);
        end
      end
    end
  end

  assign txd_o   = txd_q;
  assign empty_o = !hold_full;
  assign done_o  = !hold_full && !busy;

  p_load_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && hold_full) |=> busy);
  p_full_write_dropped_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_i && hold_full) |=> $stable(hold_data));
  p_line_high_between_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd_q);
endmodule

// File: rtl/uart9_rx_deframe.sv
module uart9_rx_deframe
  import uart9_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          nine_i,
  input  logic          idle_clr_i,
  output logic          fd_o,
  output logic [DW-1:0] fd_data_o,
  output logic          fd_b8_o,
  output logic          fd_stop_o,
  output logic          fd_msb_o,
  output logic          start_o,
  output logic          idle_evt_o
);
  localparam int TW  = $clog2(OVS);
  localparam int IW  = $clog2(DW + 3);
  localparam int MID = OVS / 2;
  localparam int CW  = $clog2((DW + 3) * OVS + 1);
  localparam logic [TW-1:0] T_A   = TW'(MID - 1);
  localparam logic [TW-1:0] T_B   = TW'(MID);
  localparam logic [TW-1:0] T_C   = TW'(MID + 1);
  localparam logic [TW-1:0] TLAST = TW'(OVS - 1);
  localparam logic [IW-1:0] STOP8 = IW'(DW + 1);
  localparam logic [IW-1:0] STOP9 = IW'(DW + 2);
  localparam logic [CW-1:0] ILIM8 = CW'((DW + 2) * OVS);
  localparam logic [CW-1:0] ILIM9 = CW'((DW + 3) * OVS);

  logic          rx_m, rx_s;
  rx_state_e     st;
  logic [IW-1:0] idx;
  logic [TW-1:0] tcnt;
  logic          s_a, s_b;
  logic [DW:0]   sh;
  logic [CW-1:0] icnt;
  logic          vote;
  logic [DW-1:0] data_w;
  logic          b8_w;
  logic [IW-1:0] stop_idx;
  logic [CW-1:0] ilim;

  assign vote     = maj3(s_a, s_b, rx_s);
  assign data_w   = nine_i ? sh[DW-1:0] : sh[DW:1];
  assign b8_w     = nine_i ? sh[DW] : 1'b0;
  assign stop_idx = nine_i ? STOP9 : STOP8;
  assign ilim     = nine_i ? ILIM9 : ILIM8;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd_i;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      idx       <= '0;
      tcnt      <= '0;
      s_a       <= 1'b1;
      s_b       <= 1'b1;
      sh        <= '0;
      fd_o      <= 1'b0;
      fd_data_o <= '0;
      fd_b8_o   <= 1'b0;
      fd_stop_o <= 1'b1;
      fd_msb_o  <= 1'b0;
      start_o   <= 1'b0;
    end else begin
      fd_o    <= 1'b0;
      start_o <= 1'b0;
      if (tick_i) begin
        if (st == RX_IDLE) begin
          if (!rx_s) begin
            st      <= RX_RUN;
            idx     <= '0;
            tcnt    <= TW'(1);
            start_o <= 1'b1;
          end
        end else begin
          if (tcnt == T_A) s_a <= rx_s;
          if (tcnt == T_B) s_b <= rx_s;
          if (tcnt == T_C) begin
            if (idx == '0) begin
              if (vote) st <= RX_IDLE;
            end else if (idx == stop_idx) begin
              st        <= RX_IDLE;
              fd_o      <= 1'b1;
              fd_data_o <= data_w;
              fd_b8_o   <= b8_w;
              fd_stop_o <= vote;
              fd_msb_o  <= nine_i ? b8_w : data_w[DW-1];
            end else begin
              sh <= {vote, sh[DW:1]};
            end
          end
          if (tcnt == TLAST) begin
            tcnt <= '0;
            idx  <= idx + IW'(1);
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
      end
    end
  end

  // Idle-line counter: ticks of continuous 1 while no frame is in progress.
  always_ff @(posedge clk) begin
    if (rst) begin
      icnt       <= '0;
      idle_evt_o <= 1'b0;
    end else begin
      idle_evt_o <= 1'b0;
      if (idle_clr_i) begin
        icnt <= '0;
      end else if (tick_i) begin
        if (st != RX_IDLE || !rx_s) begin
          icnt <= '0;
        end else if (icnt != ilim) begin
          icnt <= icnt + CW'(1);
          if (icnt == ilim - CW'(1)) idle_evt_o <= 1'b1;
        end
      end
    end
  end

  p_start_seen_low_r11: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !$past(rx_s));
  p_idle_only_when_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    idle_evt_o |-> (st == RX_IDLE));
  p_frame_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    fd_o |=> !fd_o);
endmodule

// File: rtl/uart9_rx_buf.sv
module uart9_rx_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_i,
  input  logic [DW-1:0] data_i,
  input  logic          b8_i,
  input  logic          stop_i,
  input  logic          rd_i,
  input  logic          start_i,
  input  logic          idle_i,
  input  logic          asleep_i,
  output logic [DW-1:0] rd_data_o,
  output logic          b8_o,
  output logic          full_o,
  output logic          ovr_o,
  output logic          ferr_o,
  output logic          idle_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
      b8_o      <= 1'b0;
      full_o    <= 1'b0;
      ovr_o     <= 1'b0;
      ferr_o    <= 1'b0;
      idle_o    <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (rd_i) begin
        full_o <= 1'b0;
        ovr_o  <= 1'b0;
        ferr_o <= 1'b0;
      end
      if (acc_i) begin
        armed <= 1'b1;
        if (full_o && !rd_i) begin
          ovr_o <= 1'b1;
        end else begin
          rd_data_o <= data_i;
          b8_o      <= b8_i;
          full_o    <= 1'b1;
          ferr_o    <= !stop_i;
        end
      end
      if (start_i) begin
        idle_o <= 1'b0;
      end else if (idle_i && armed && !asleep_i) begin
        idle_o <= 1'b1;
        armed  <= 1'b0;
      end
    end
  end

  p_overrun_needs_full_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_o) |-> $past(full_o));
  p_overrun_keeps_data_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_i && full_o && !rd_i) |=> $stable(rd_data_o));
  p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !acc_i) |=> (!full_o && !ovr_o && !ferr_o));
endmodule

// File: rtl/uart9_wakeup.sv
module uart9_wakeup (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req_i,
  input  logic wake_addr_i,
  input  logic fd_i,
  input  logic msb_i,
  input  logic idle_i,
  output logic asleep_o,
  output logic acc_o
);
  logic wake_hit;

  assign wake_hit = wake_addr_i ? (fd_i && msb_i) : idle_i;
  assign acc_o    = fd_i && (!asleep_o || (wake_addr_i && msb_i));

  always_ff @(posedge clk) begin
    if (rst)                      asleep_o <= 1'b0;
    else if (sleep_req_i)         asleep_o <= 1'b1;
    else if (asleep_o && wake_hit) asleep_o <= 1'b0;
  end

  p_wake_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep_o) |-> $past(wake_addr_i ? (fd_i && msb_i) : idle_i));
  p_sleep_on_request_r9: assert property (@(posedge clk) disable iff (rst)
    sleep_req_i |=> asleep_o);
endmodule

// File: rtl/uart9_wake.sv
module uart9_wake #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud16_tick,
  input  logic          rxd,
  output logic          txd,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          cfg_nine,
  input  logic          cfg_wake_addr,
  input  logic          tx_bit8,
  output logic          rx_bit8,
  input  logic          sleep_req,
  output logic          rx_asleep,
  output logic          tx_empty,
  output logic          tx_done,
  output logic          rx_full,
  output logic          rx_overrun,
  output logic          rx_frame_err,
  output logic          rx_idle
);
  logic          fd, fd_b8, fd_stop, fd_msb, start_evt, idle_evt, acc;
  logic [DW-1:0] fd_data;

  uart9_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick_i(baud16_tick), .nine_i(cfg_nine),
    .wr_i(data_wr), .wr_data_i(wr_data), .b8_i(tx_bit8),
    .txd_o(txd), .empty_o(tx_empty), .done_o(tx_done)
  );

  uart9_rx_deframe #(.DW(DW), .OVS(OVS)) u_deframe (
    .clk(clk), .rst(rst), .tick_i(baud16_tick), .rxd_i(rxd),
    .nine_i(cfg_nine), .idle_clr_i(sleep_req),
    .fd_o(fd), .fd_data_o(fd_data), .fd_b8_o(fd_b8), .fd_stop_o(fd_stop),
    .fd_msb_o(fd_msb), .start_o(start_evt), .idle_evt_o(idle_evt)
  );

  uart9_wakeup u_wakeup (
    .clk(clk), .rst(rst), .sleep_req_i(sleep_req), .wake_addr_i(cfg_wake_addr),
    .fd_i(fd), .msb_i(fd_msb), .idle_i(idle_evt),
    .asleep_o(rx_asleep), .acc_o(acc)
  );

  uart9_rx_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst), .acc_i(acc), .data_i(fd_data), .b8_i(fd_b8),
    .stop_i(fd_stop), .rd_i(data_rd), .start_i(start_evt), .idle_i(idle_evt),
    .asleep_i(rx_asleep), .rd_data_o(rd_data), .b8_o(rx_bit8),
    .full_o(rx_full), .ovr_o(rx_overrun), .ferr_o(rx_frame_err), .idle_o(rx_idle)
  );

  p_asleep_discards_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_asleep && fd && !(cfg_wake_addr && fd_msb) && !data_rd) |=> $stable(rx_full));
endmodule

// File: tb/uart9_wake_tb.sv
module uart9_wake_tb;
  localparam int CLK_NS = 10;
  localparam int BITCLK = 64;   // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick;
  logic [1:0] tc;
  logic       rxd = 1'b1;
  logic       txd;
  logic       data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cfg_nine = 1'b0, cfg_wake_addr = 1'b0, tx_bit8 = 1'b0, sleep_req = 1'b0;
  logic       rx_bit8, rx_asleep, tx_empty, tx_done, rx_full, rx_overrun, rx_frame_err, rx_idle;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) tc <= 2'd0;
    else     tc <= tc + 2'd1;
  end
  assign tick = (tc == 2'd3);

  uart9_wake u_dut (
    .clk(clk), .rst(rst), .baud16_tick(tick), .rxd(rxd), .txd(txd),
    .data_wr(data_wr), .data_rd(data_rd), .wr_data(wr_data), .rd_data(rd_data),
    .cfg_nine(cfg_nine), .cfg_wake_addr(cfg_wake_addr), .tx_bit8(tx_bit8),
    .rx_bit8(rx_bit8), .sleep_req(sleep_req), .rx_asleep(rx_asleep),
    .tx_empty(tx_empty), .tx_done(tx_done), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err), .rx_idle(rx_idle)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] d, input logic b8);
    @(negedge clk);
    data_wr = 1'b1; wr_data = d; tx_bit8 = b8;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  // Drive one frame; glitch_bit >= 0 inverts the line for 4 clocks in mid-bit.
  task automatic send_frame(input logic [8:0] d, input logic nine, input logic stopv,
                            input int glitch_bit);
    int nb;
    logic v;
    nb = nine ? 11 : 10;
    for (int i = 0; i < nb; i++) begin
      if (i == 0)           v = 1'b0;
      else if (i == nb - 1) v = stopv;
      else                  v = d[i-1];
      @(negedge clk);
      rxd = v;
      if (i == glitch_bit) begin
        wait_clk(29); rxd = ~v; wait_clk(4); rxd = v; wait_clk(BITCLK - 34);
      end else begin
        wait_clk(BITCLK - 1);
      end
    end
    @(negedge clk); rxd = 1'b1;
  endtask

  task automatic cap_tx(input int nb, output logic [10:0] bits);
    int guard;
    bits = '1;
    guard = 0;
    while (txd !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    wait_clk(BITCLK / 2);
    bits[0] = txd;
    for (int i = 1; i < nb; i++) begin
      wait_clk(BITCLK);
      bits[i] = txd;
    end
  endtask

  task automatic t_reset();
    chk("R1 txd", txd, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 tx_done", tx_done, 1);
    chk("R1 rx flags", {rx_full, rx_overrun, rx_frame_err, rx_idle, rx_asleep}, 0);
  endtask

  task automatic t_tx8();
    logic [10:0] b;
    cfg_nine = 1'b0;
    host_write(8'hA5, 1'b0);
    cap_tx(10, b);
    chk("R2 frame8", b[9:0], {1'b1, 8'hA5, 1'b0});
    wait_clk(BITCLK);
    chk("R2 idle high", txd, 1);
  endtask

  task automatic t_tx9();
    logic [10:0] b;
    cfg_nine = 1'b1;
    host_write(8'h3C, 1'b1);
    cap_tx(11, b);
    chk("R3 frame9", b, {1'b1, 1'b1, 8'h3C, 1'b0});
    wait_clk(BITCLK);
    cfg_nine = 1'b0;
  endtask

  task automatic t_tx_dbl();
    logic [10:0] a, b;
    int lows;
    host_write(8'h5E, 1'b0);
    wait_clk(2);
    host_write(8'hC3, 1'b0);
    chk("R4 empty low when held", tx_empty, 0);
    chk("R4 done low", tx_done, 0);
    host_write(8'hFF, 1'b0);   // dropped: holding register full
    cap_tx(10, a);
    cap_tx(10, b);
    chk("R4 first char", a[9:0], {1'b1, 8'h5E, 1'b0});
    chk("R4 back-to-back second", b[9:0], {1'b1, 8'hC3, 1'b0});
    lows = 0;
    for (int i = 0; i < 20 * BITCLK; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk("R4 dropped write not sent", lows, 0);
    chk("R4 done after drain", tx_done, 1);
  endtask

  task automatic t_rx8();
    send_frame(9'h05A, 1'b0, 1'b1, -1);
    chk("R5 rx_full", rx_full, 1);
    chk("R5 rd_data", rd_data, 8'h5A);
    chk("R7 no frame err", rx_frame_err, 0);
    host_read();
    chk("R5 read clears", rx_full, 0);
  endtask

  task automatic t_rx9();
    cfg_nine = 1'b1;
    send_frame(9'h1A5, 1'b1, 1'b1, -1);
    chk("R3 rx data9", rd_data, 8'hA5);
    chk("R3 rx_bit8", rx_bit8, 1);
    host_read();
    cfg_nine = 1'b0;
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 1'b0, 1'b1, -1);
    send_frame(9'h022, 1'b0, 1'b1, -1);
    chk("R6 overrun", rx_overrun, 1);
    chk("R6 old data kept", rd_data, 8'h11);
    host_read();
    chk("R6 read clears full+overrun", {rx_full, rx_overrun}, 0);
  endtask

  task automatic t_ferr();
    send_frame(9'h0C7, 1'b0, 1'b0, -1);
    wait_clk(2 * BITCLK);
    chk("R7 frame err", rx_frame_err, 1);
    chk("R7 data delivered", rd_data, 8'hC7);
    host_read();
    chk("R7 read clears", {rx_full, rx_frame_err}, 0);
  endtask

  task automatic t_vote();
    @(negedge clk); rxd = 1'b0; wait_clk(4); rxd = 1'b1;
    wait_clk(3 * BITCLK);
    chk("R11 short low no frame", rx_full, 0);
    send_frame(9'h000, 1'b0, 1'b1, 4);
    chk("R11 glitch voted out", rd_data, 8'h00);
    host_read();
  endtask

  task automatic t_idle_flag();
    send_frame(9'h066, 1'b0, 1'b1, -1);
    chk("R10 idle cleared by start", rx_idle, 0);
    wait_clk(8 * BITCLK);
    chk("R10 not yet idle", rx_idle, 0);
    wait_clk(4 * BITCLK);
    chk("R10 idle after frame time", rx_idle, 1);
    host_read();
  endtask

  task automatic t_wake_addr();
    cfg_wake_addr = 1'b1;
    pulse_sleep();
    chk("R8 asleep", rx_asleep, 1);
    send_frame(9'h012, 1'b0, 1'b1, -1);
    chk("R8 data char discarded", {rx_asleep, rx_full}, 2'b10);
    send_frame(9'h081, 1'b0, 1'b1, -1);
    chk("R8 address wakes", rx_asleep, 0);
    chk("R8 address delivered", {rx_full, rd_data}, {1'b1, 8'h81});
    host_read();
    cfg_nine = 1'b1;
    pulse_sleep();
    send_frame(9'h080, 1'b1, 1'b1, -1);
    chk("R8 nine: bit7 no wake", {rx_asleep, rx_full}, 2'b10);
    send_frame(9'h105, 1'b1, 1'b1, -1);
    chk("R8 nine: bit8 wakes", {rx_asleep, rx_full, rx_bit8, rd_data}, {3'b011, 8'h05});
    host_read();
    cfg_nine = 1'b0;
    cfg_wake_addr = 1'b0;
  endtask

  task automatic t_wake_idle();
    cfg_wake_addr = 1'b0;
    wait_clk(2 * BITCLK);
    pulse_sleep();
    send_frame(9'h033, 1'b0, 1'b1, -1);
    chk("R9 discarded while asleep", {rx_asleep, rx_full}, 2'b10);
    wait_clk(8 * BITCLK);
    chk("R9 still asleep", rx_asleep, 1);
    wait_clk(4 * BITCLK);
    chk("R9 woke on idle", rx_asleep, 0);
    send_frame(9'h044, 1'b0, 1'b1, -1);
    chk("R9 receives after wake", {rx_full, rd_data}, {1'b1, 8'h44});
    host_read();
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_tx8();
    t_tx9();
    t_tx_dbl();
    t_rx8();
    t_rx9();
    t_overrun();
    t_ferr();
    t_vote();
    t_idle_flag();
    t_wake_addr();
    t_wake_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule